// File: doc/BRIEF.md
# Windowed Watchdog with Pulsed Fault

This block supervises a processor's liveness signal. Software toggles a kick line, and the block measures the time between successive falling edges of that line. An edge that comes too soon after the previous one is a fast fault, and a missing edge past the upper limit is a slow fault. Either fault drives an active-low fault output for a fixed number of cycles. The output is meant to be looped into an interrupt or into a manual-reset path.

Before anything is measured, the kick line passes through a width qualifier. A level change is accepted only after the line has held the new level for a parameterized number of consecutive cycles, so narrow glitches have no effect. While the system is in reset, while manual reset is requested, or while a fault pulse is running, accepted edges are discarded and the timer is held. When such a hold ends, the first edge is exempt from the early-edge check.

All limits are in clock cycles. Each accepted edge starts a new measurement. Let P be the number of cycles from one accepted edge (or from the end of a hold) to the next accepted edge. P < FAST_LIM is a fast fault. FAST_LIM <= P <= SLOW_LIM is a valid kick. If no accepted edge has arrived by cycle SLOW_LIM, a slow fault is raised in that cycle.

Top module: `window_watchdog`

## Requirements
- R1: A falling edge is accepted only after kick_i has been sampled low on MIN_W consecutive clock edges following a qualified-high level. A return to the high level likewise needs MIN_W consecutive high samples. Low pulses of MIN_W-1 samples or fewer have no effect on the fault outputs.
- R2: Every accepted edge restarts the measurement, so each window is counted from the most recent accepted edge. A steady stream of valid kicks never produces a fault.
- R3: If no accepted edge arrives, a slow fault is decided in cycle SLOW_LIM after the last accepted edge or hold release.
- R4: An accepted edge with P < FAST_LIM after the previous accepted edge raises a fast fault, unless it is the first edge after a release.
- R5: An accepted edge with FAST_LIM <= P <= SLOW_LIM is valid: it raises no fault and restarts the measurement. This includes both P = FAST_LIM and P = SLOW_LIM.
- R6: On a fault decision, fault_no goes low in the next cycle and stays low for exactly PULSE_LEN cycles. fault_no is high in the reset state.
- R7: fault_fast_o or fault_slow_o, never both, is high for exactly the first cycle of the pulse, and names the fault type.
- R8: Accepted edges are discarded while sys_rst_ni is low, mrst_i is high or the fault pulse is running.
- R9: When a hold ends (system reset release, manual reset release or pulse end), the measurement restarts from the release, and the first accepted edge is exempt from the fast check.
- R10: sys_rst_ni low or mrst_i high releases fault_no (high) from the next cycle, and holds the timer cleared for as long as it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| kick_i | input | 1 | Synchronized kick line; falling edges are kicks |
| sys_rst_ni | input | 1 | System reset state, low while the system is held in reset |
| mrst_i | input | 1 | Manual reset request, active high |
| fault_no | output | 1 | Active-low fault pulse |
| fault_fast_o | output | 1 | One-cycle flag: pulse caused by a fast fault |
| fault_slow_o | output | 1 | One-cycle flag: pulse caused by a slow fault |

## Verification
The hardest situation to reach is an accepted edge that falls inside a running fault pulse and is then correctly dropped. Reaching it needs a fast fault, followed by a third kick placed so that its qualified edge lands in the last pulse cycle. The stimulus uses a kick task whose low-plus-high period fixes the edge spacing exactly. With that task, edges are placed on both sides of FAST_LIM and SLOW_LIM, and inside pulses and holds.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_FAST = 2'd1,
    HIT_SLOW = 2'd2
  } hit_e;
endpackage

// File: rtl/kick_qual.sv
module kick_qual #(
  parameter int unsigned MIN_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic fall_o
);
  localparam int unsigned RW = (MIN_W > 1) ? $clog2(MIN_W) : 1;
  localparam logic [RW-1:0] RUN_END = RW'(MIN_W - 1);

  logic          lvl_q;
  logic [RW-1:0] run_q;
  logic          fall_q;
  logic          flip;

  assign flip = (kick_i != lvl_q) && (run_q == RUN_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b1;
      run_q  <= '0;
      fall_q <= 1'b0;
    end else begin
      fall_q <= flip && lvl_q;
      if (kick_i == lvl_q) begin
        run_q <= '0;
      end else if (flip) begin
        lvl_q <= kick_i;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign fall_o = fall_q;

  AST_FALL_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_q |-> !$past(kick_i)); // R1
  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_q |=> !fall_q); // R1
endmodule

// File: rtl/win_timer.sv
module win_timer
  import wdw_pkg::*;
#(
  parameter int unsigned FAST_LIM = 2000,
  parameter int unsigned SLOW_LIM = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic fall_i,
  output hit_e hit_o
);
  localparam int unsigned CW = $clog2(SLOW_LIM + 1);
  localparam logic [CW-1:0] FAST_C = CW'(FAST_LIM);
  localparam logic [CW-1:0] SLOW_C = CW'(SLOW_LIM);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          first_q;
  hit_e          hit;

  always_comb begin
    hit = HIT_NONE;
    if (!hold_i) begin
      if (fall_i) begin
        if (!first_q && (cnt_q < FAST_C)) hit = HIT_FAST;
      end else if (cnt_q >= SLOW_C) begin
        hit = HIT_SLOW;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= ONE_C;
      first_q <= 1'b1;
    end else if (hold_i) begin
      cnt_q   <= ONE_C;
      first_q <= 1'b1;
    end else if (fall_i) begin
      cnt_q   <= ONE_C;
      first_q <= 1'b0;
    end else if (cnt_q >= SLOW_C) begin
      cnt_q   <= ONE_C;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign hit_o = hit;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= ONE_C) && (cnt_q <= SLOW_C)); // R3
  AST_HOLD_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == ONE_C) && first_q); // R9
  AST_FALL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !hold_i) |=> (cnt_q == ONE_C) && !first_q); // R2
endmodule

// File: rtl/fault_pulse.sv
module fault_pulse
  import wdw_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  input  hit_e hit_i,
  output logic active_o,
  output logic fast_o,
  output logic slow_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LEN_C = PW'(PULSE_LEN);

  logic [PW-1:0] pcnt_q;
  logic          fast_q;
  logic          slow_q;
  logic          active;

  assign active = (pcnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      fast_q <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      fast_q <= (hit_i == HIT_FAST) && !force_i;
      slow_q <= (hit_i == HIT_SLOW) && !force_i;
      if (force_i)                    pcnt_q <= '0;
      else if (hit_i != HIT_NONE)     pcnt_q <= LEN_C;
      else if (active)                pcnt_q <= pcnt_q - 1'b1;
    end
  end

  assign active_o = active;
  assign fast_o   = fast_q;
  assign slow_o   = slow_q;

  AST_FORCE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> !active); // R10
  AST_IND_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fast_q, slow_q})); // R7
  AST_IND_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_q || slow_q) |-> $rose(active)); // R7
  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != HIT_NONE && !force_i) |=> active); // R6
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wdw_pkg::*;
#(
  parameter int unsigned FAST_LIM  = 2000,
  parameter int unsigned SLOW_LIM  = 20000,
  parameter int unsigned PULSE_LEN = 1000,
  parameter int unsigned MIN_W     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  input  logic sys_rst_ni,
  input  logic mrst_i,
  output logic fault_no,
  output logic fault_fast_o,
  output logic fault_slow_o
);
  logic fall;
  logic force_rel;
  logic hold;
  logic active;
  hit_e hit;

  assign force_rel = !sys_rst_ni || mrst_i;
  assign hold      = force_rel || active;

  kick_qual #(.MIN_W(MIN_W)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (kick_i),
    .fall_o (fall)
  );

  win_timer #(.FAST_LIM(FAST_LIM), .SLOW_LIM(SLOW_LIM)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .fall_i (fall),
    .hit_o  (hit)
  );

  fault_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .force_i  (force_rel),
    .hit_i    (hit),
    .active_o (active),
    .fast_o   (fault_fast_o),
    .slow_o   (fault_slow_o)
  );

  assign fault_no = !active;

  AST_NO_HIT_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |-> (hit == HIT_NONE)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_ni |=> fault_no); // R10
endmodule

// File: tb/window_watchdog_tb_top.sv
`timescale 1ns/1ps
module window_watchdog_tb_top;
  localparam int F  = 20;
  localparam int S  = 60;
  localparam int PL = 10;
  localparam int MW = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic kick_i = 1'b1;
  logic sys_rst_ni = 1'b0;
  logic mrst_i = 1'b0;
  logic fault_no, fault_fast_o, fault_slow_o;

  always #2.5 clk_i = ~clk_i;

  window_watchdog #(.FAST_LIM(F), .SLOW_LIM(S), .PULSE_LEN(PL), .MIN_W(MW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .kick_i(kick_i), .sys_rst_ni(sys_rst_ni),
    .mrst_i(mrst_i), .fault_no(fault_no), .fault_fast_o(fault_fast_o),
    .fault_slow_o(fault_slow_o));

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R6";

  // behavioural reference
  int m_lvl = 1, m_run = 0, m_fall = 0, m_age = 1, m_first = 1, m_pl = 0, m_fast = 0, m_slow = 0;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lvl = 1; m_run = 0; m_fall = 0; m_age = 1; m_first = 1;
      m_pl = 0; m_fast = 0; m_slow = 0;
    end else begin
      int nf, hf, hs;
      bit hold, frc;
      frc  = !sys_rst_ni || mrst_i;
      hold = frc || (m_pl > 0);
      nf = (m_lvl == 1 && kick_i == 1'b0 && m_run == MW - 1) ? 1 : 0;
      hf = 0; hs = 0;
      if (hold) begin m_age = 1; m_first = 1; end
      else if (m_fall != 0) begin
        if (m_first == 0 && m_age < F) hf = 1;
        m_age = 1; m_first = 0;
      end else if (m_age >= S) begin hs = 1; m_age = 1; end
      else m_age++;
      if (int'(kick_i) == m_lvl) m_run = 0;
      else if (m_run == MW - 1) begin m_lvl = int'(kick_i); m_run = 0; end
      else m_run++;
      if (frc) m_pl = 0;
      else if (hf != 0 || hs != 0) m_pl = PL;
      else if (m_pl > 0) m_pl--;
      m_fall = nf; m_fast = hf; m_slow = hs;
    end
  end

  // observation of ports
  int n_fast = 0, n_slow = 0, low_run = 0, last_w = 0;
  bit done = 0;
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      n_cmp++;
      if ({fault_no, fault_fast_o, fault_slow_o} !=
          {(m_pl == 0), (m_fast != 0), (m_slow != 0)}) begin
        n_bad++;
        $display("FAIL %s: outputs no/fast/slow=%b%b%b expected %b%b%b at %0t", cur_req,
                 fault_no, fault_fast_o, fault_slow_o, (m_pl == 0), (m_fast != 0),
                 (m_slow != 0), $time);
      end
      if (fault_fast_o) n_fast++;
      if (fault_slow_o) n_slow++;
      if (!fault_no) low_run++;
      else if (low_run > 0) begin last_w = low_run; low_run = 0; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // one kick: P = lo + hi cycles between consecutive accepted edges
  task automatic kick(input int lo, input int hi);
    @(negedge clk_i); kick_i = 1'b0;
    repeat (lo - 1) @(negedge clk_i);
    @(negedge clk_i); kick_i = 1'b1;
    repeat (hi - 1) @(negedge clk_i);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    done = 1;
    summary();
  end

  initial begin
    int b_f, b_s;
    idle(3);
    chk("R6 reset state fault_no", int'(fault_no), 1);
    chk("R7 reset state flags", int'(fault_fast_o | fault_slow_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;

    cur_req = "R8";
    repeat (5) kick(4, 6);
    idle(80);
    chk("R8 kicks in system reset ignored", n_fast + n_slow, 0);
    chk("R10 fault_no high in system reset", int'(fault_no), 1);

    cur_req = "R9";
    @(negedge clk_i); sys_rst_ni = 1'b1;
    repeat (4) kick(4, 26);
    chk("R9 first edge after release exempt", n_fast, 0);
    cur_req = "R2";
    repeat (4) kick(4, 26);
    chk("R2 steady kicks no slow fault", n_slow, 0);

    cur_req = "R5";
    kick(4, F - 4);
    kick(4, 26);
    chk("R5 edge at exactly FAST_LIM valid", n_fast, 0);

    cur_req = "R4";
    kick(4, F - 5);
    kick(4, 26);
    chk("R4 edge one cycle early is fast fault", n_fast, 1);
    idle(2);
    chk("R6 pulse width", last_w, PL);
    chk("R7 fast flag count", n_slow, 0);

    cur_req = "R3";
    idle(70);
    chk("R3 silence gives slow fault", n_slow, 1);
    idle(5);
    chk("R6 slow pulse width", last_w, PL);

    cur_req = "R5";
    kick(4, 26);
    kick(4, S - 4);
    b_s = n_slow;
    kick(4, 26);
    chk("R5 edge at exactly SLOW_LIM valid", n_slow, b_s);
    cur_req = "R3";
    kick(4, S - 3);
    kick(4, 26);
    chk("R3 edge one cycle late is slow fault", n_slow, b_s + 1);

    cur_req = "R1";
    idle(20);
    kick(4, 26);
    b_f = n_fast; b_s = n_slow;
    repeat (3) kick(MW - 1, 4);
    idle(12);
    kick(4, 26);
    chk("R1 narrow lows ignored (fast)", n_fast, b_f);
    chk("R1 narrow lows ignored (slow)", n_slow, b_s);

    cur_req = "R8";
    b_f = n_fast;
    kick(4, 6);
    kick(4, 6);
    kick(4, 26);
    idle(10);
    chk("R8 edge inside pulse ignored", n_fast, b_f + 1);

    cur_req = "R10";
    kick(4, 26);
    kick(4, 6);
    kick(4, 6);
    chk("R10 pulse running before manual reset", int'(fault_no), 0);
    mrst_i = 1'b1;
    @(negedge clk_i);
    chk("R10 manual reset releases fault_no", int'(fault_no), 1);
    idle(S + 10);
    chk("R10 manual reset holds timer", int'(fault_no), 1);
    mrst_i = 1'b0;
    cur_req = "R9";
    kick(4, 26);
    idle(S + 5);
    chk("R9 slow after manual release", n_slow > b_s ? 1 : 0, 1);
    idle(20);
    done = 1;
    summary();
  end
endmodule